// File: doc/BRIEF.md
# Video raster timing and sync-status generator

This block follows the raster position of a video output. A dot counter runs along each line, stepped by a dot-clock enable. A line counter runs through each field. In interlaced mode an odd/even field flag flips at every field wrap. A frame counter steps each time the raster enters the fixed retrace-end line, which is line 42.

Four writable registers set the timing: raster totals, sync configuration, sync widths and porch widths. A fifth, read-only register gives a live status word. It packs the current line, the field flag, a display-active flag and two sync-off flags. Software reaches all of these through a synchronous word-addressed register port. The line count, dot count, field flag and frame count are also driven straight out for neighbouring blocks.

Register word addresses: 0 totals, 1 sync configuration, 2 sync widths, 3 porches, 4 status. Addresses 5 to 7 are unmapped.

Top module: `raster_timing_gen`

## Requirements
- R1: After reset the dot count, line count, field flag and frame count are zero, and the totals register (address 0) reads 0x0270035F, which is 625 lines of 864 dots.
- R2: A write to the totals register stores the value masked with 0x03FF03FF. Total lines is bits 25:16 plus 1 and dots per line is bits 9:0 plus 1. The same write clears the dot and line counters on that clock edge.
- R3: The dot counter advances by one only in cycles with dot_en high. From dots-per-line minus 1 it returns to 0 and the line advances.
- R4: When the line counter leaves total lines minus 1 it returns to 0. At that wrap the field flag toggles if sync-configuration bit 4 (interlace) is 1, and holds otherwise.
- R5: The sync configuration register keeps bits 9:0. The sync-width register keeps bits 11:8 (vsync lines V) and 6:0 (hsync code H, giving an hsync width of 2*(H+1) dots). The porch register keeps bits 9:0 (front porch F, in dots) and bits 25:16 (back porch B, in dots). Each register reads back its masked value.
- R6: The frame counter increments by one exactly when a line advance makes the line count equal 42.
- R7: A read (reg_rd high) returns the addressed value on reg_rdata at the next clock edge. The status word at address 4 is sampled live and holds the line count in bits 9:0, the field flag in bit 10 (1 = odd), display-active in bit 11, hsync-off in bit 12 and vsync-off in bit 13. Its other bits are 0.
- R8: On a line whose bit 0 equals the field flag, hsync-off is 1 when the dot count exceeds 2*(H+1). If the line count is at least V, vsync-off is 1, and display-active is 1 when the dot count also exceeds F.
- R9: On a line whose bit 0 differs from the field flag, with the line count at least V: hsync-off, vsync-off and display-active are all 1 while the dot count is below dots-per-line minus B, floored at 0. Otherwise only hsync-off is 1. Below V all three flags are 0.
- R10: Writes to address 4 or to addresses 5 to 7 change no register, counter or status bit. Reads of addresses 5 to 7 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dot_en | input | 1 | Dot-clock enable, one dot per high cycle |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after reg_rd |
| line_cnt | output | 10 | Current line within the field |
| dot_cnt | output | 10 | Current dot within the line |
| field_odd | output | 1 | Field flag, 1 = odd |
| frame_cnt | output | 16 | Frames counted at the retrace-end line |

## Verification
The hardest case to reach from the ports is the status word on a line whose parity does not match the field flag. That case needs a field toggle, so the raster must wrap a whole field with interlace enabled. At the reset totals this takes over half a million dots. The stimulus therefore programs random small totals of 44 to 60 lines and 16 to 40 dots, with interlace mostly on. It then runs several thousand cycles per setting with a dense random dot enable and frequent status reads. Both field phases, both line parities, the line-42 frame crossing and the porch and sync thresholds then recur many times under each setting.

// File: rtl/raster_pkg.sv
// Shared widths, register addresses, masks and reset values for the raster
// timing generator. Assumes 32-bit register words and word addressing.
package raster_pkg;
    localparam int DW      = 32;
    localparam int AW      = 3;
    localparam int LINE_W  = 10;
    localparam int DOT_W   = 10;
    localparam int FRAME_W = 16;
    localparam int VS_W    = 4;
    localparam int HSW_W   = 7;
    localparam int STAT_W  = LINE_W + 4;

    typedef enum logic [AW-1:0] {
        A_TOTAL    = 3'd0,
        A_SYNC_CFG = 3'd1,
        A_SYNC_WID = 3'd2,
        A_PORCH    = 3'd3,
        A_STATUS   = 3'd4
    } reg_addr_e;

    localparam logic [DW-1:0] TOTAL_MASK = 32'h03FF_03FF;
    localparam logic [DW-1:0] CFG_MASK   = 32'h0000_03FF;
    localparam logic [DW-1:0] WID_MASK   = 32'h0000_0F7F;
    localparam logic [DW-1:0] PORCH_MASK = 32'h03FF_03FF;
    localparam logic [DW-1:0] TOTAL_RST  = 32'h0270_035F;
    localparam logic [LINE_W-1:0] RETRACE_END = 10'd42;
    localparam int INTERLACE_BIT = 4;
endpackage

// File: rtl/raster_regs.sv
// Register file and read port. Holds the four timing registers in masked
// form, decodes their fields and returns read data one cycle after reg_rd.
// Assumes the status word is supplied live by the status logic.
module raster_regs
    import raster_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [AW-1:0]     reg_addr,
    input  logic [DW-1:0]     reg_wdata,
    input  logic [STAT_W-1:0] status,
    output logic [DW-1:0]     reg_rdata,
    output logic              total_wr,
    output logic [LINE_W-1:0] lines_m1,
    output logic [DOT_W-1:0]  dots_m1,
    output logic              interlace,
    output logic [VS_W-1:0]   vs_lines,
    output logic [HSW_W-1:0]  hsw_code,
    output logic [DOT_W-1:0]  front_dots,
    output logic [DOT_W-1:0]  back_dots
);
    logic [DW-1:0] r_total, r_cfg, r_wid, r_porch;
    logic [DW-1:0] rd_mux;

    // Strobe that tells the counters to restart on a totals write.
    assign total_wr = reg_wr && (reg_addr == A_TOTAL);

    // Store masked register words on write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_total <= TOTAL_RST;
            r_cfg   <= '0;
            r_wid   <= '0;
            r_porch <= '0;
        end else if (reg_wr) begin
            case (reg_addr)
                A_TOTAL:    r_total <= reg_wdata & TOTAL_MASK;
                A_SYNC_CFG: r_cfg   <= reg_wdata & CFG_MASK;
                A_SYNC_WID: r_wid   <= reg_wdata & WID_MASK;
                A_PORCH:    r_porch <= reg_wdata & PORCH_MASK;
                default:    ;
            endcase
        end
    end

    // Field decode for the counter and status logic.
    assign lines_m1   = r_total[16 +: LINE_W];
    assign dots_m1    = r_total[0 +: DOT_W];
    assign interlace  = r_cfg[INTERLACE_BIT];
    assign vs_lines   = r_wid[8 +: VS_W];
    assign hsw_code   = r_wid[0 +: HSW_W];
    assign front_dots = r_porch[0 +: DOT_W];
    assign back_dots  = r_porch[16 +: DOT_W];

    // Read selection.
    always_comb begin
        case (reg_addr)
            A_TOTAL:    rd_mux = r_total;
            A_SYNC_CFG: rd_mux = r_cfg;
            A_SYNC_WID: rd_mux = r_wid;
            A_PORCH:    rd_mux = r_porch;
            A_STATUS:   rd_mux = {{(DW-STAT_W){1'b0}}, status};
            default:    rd_mux = '0;
        endcase
    end

    // Register the read data on a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)      reg_rdata <= '0;
        else if (reg_rd) reg_rdata <= rd_mux;
    end
endmodule

// File: rtl/raster_counter.sv
// Dot, line, field and frame counters. Steps one dot per dot_en cycle,
// wraps lines and fields at the programmed totals and counts frames on
// entry to the retrace-end line. A clear (totals write) has priority.
module raster_counter
    import raster_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               dot_en,
    input  logic               clear,
    input  logic [LINE_W-1:0]  lines_m1,
    input  logic [DOT_W-1:0]   dots_m1,
    input  logic               interlace,
    output logic [LINE_W-1:0]  line_cnt,
    output logic [DOT_W-1:0]   dot_cnt,
    output logic               field_odd,
    output logic [FRAME_W-1:0] frame_cnt
);
    logic dot_last, line_last;
    logic [LINE_W-1:0] line_inc;

    // Wrap conditions and the next line number.
    assign dot_last  = (dot_cnt == dots_m1);
    assign line_last = (line_cnt == lines_m1);
    assign line_inc  = line_cnt + 1'b1;

    // Raster position update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dot_cnt   <= '0;
            line_cnt  <= '0;
            field_odd <= 1'b0;
            frame_cnt <= '0;
        end else if (clear) begin
            dot_cnt  <= '0;
            line_cnt <= '0;
        end else if (dot_en) begin
            if (!dot_last) begin
                dot_cnt <= dot_cnt + 1'b1;
            end else begin
                dot_cnt <= '0;
                if (line_last) begin
                    line_cnt  <= '0;
                    field_odd <= field_odd ^ interlace;
                end else begin
                    line_cnt <= line_inc;
                    if (line_inc == RETRACE_END)
                        frame_cnt <= frame_cnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/raster_status.sv
// Combinational sync-status word. Derives hsync-off, vsync-off and
// display-active from the raster position, with separate rules for lines
// whose parity matches the field flag and for the others.
module raster_status
    import raster_pkg::*;
(
    input  logic [LINE_W-1:0] line_cnt,
    input  logic [DOT_W-1:0]  dot_cnt,
    input  logic              field_odd,
    input  logic [DOT_W-1:0]  dots_m1,
    input  logic [VS_W-1:0]   vs_lines,
    input  logic [HSW_W-1:0]  hsw_code,
    input  logic [DOT_W-1:0]  front_dots,
    input  logic [DOT_W-1:0]  back_dots,
    output logic [STAT_W-1:0] status
);
    logic [DOT_W:0] hs_dots, dots_tot, back_lim, dot_x;
    logic past_vs, same_par, hoff, voff, act;

    // Thresholds in dots.
    assign hs_dots  = ({{(DOT_W+1-HSW_W){1'b0}}, hsw_code} + 1'b1) << 1;
    assign dots_tot = {1'b0, dots_m1} + 1'b1;
    assign back_lim = (dots_tot > {1'b0, back_dots}) ? dots_tot - {1'b0, back_dots} : '0;
    assign dot_x    = {1'b0, dot_cnt};
    assign past_vs  = (line_cnt >= {{(LINE_W-VS_W){1'b0}}, vs_lines});
    assign same_par = (line_cnt[0] == field_odd);

    // Flag selection for the two line classes.
    always_comb begin
        hoff = 1'b0;
        voff = 1'b0;
        act  = 1'b0;
        if (same_par) begin
            hoff = (dot_x > hs_dots);
            voff = past_vs;
            act  = past_vs && (dot_x > {1'b0, front_dots});
        end else if (past_vs) begin
            hoff = 1'b1;
            voff = (dot_x < back_lim);
            act  = (dot_x < back_lim);
        end
    end

    assign status = {voff, hoff, act, field_odd, line_cnt};
endmodule

// File: rtl/raster_timing_gen.sv
// Top of the raster timing and sync-status generator. Connects the register
// file, the raster counters and the status logic. Assumes one clock domain
// with dot_en as a clock enable.
module raster_timing_gen
    import raster_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               dot_en,
    input  logic               reg_wr,
    input  logic               reg_rd,
    input  logic [AW-1:0]      reg_addr,
    input  logic [DW-1:0]      reg_wdata,
    output logic [DW-1:0]      reg_rdata,
    output logic [LINE_W-1:0]  line_cnt,
    output logic [DOT_W-1:0]   dot_cnt,
    output logic               field_odd,
    output logic [FRAME_W-1:0] frame_cnt
);
    logic              total_wr, interlace;
    logic [LINE_W-1:0] lines_m1;
    logic [DOT_W-1:0]  dots_m1, front_dots, back_dots;
    logic [VS_W-1:0]   vs_lines;
    logic [HSW_W-1:0]  hsw_code;
    logic [STAT_W-1:0] status;

    raster_regs u_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .status(status),
        .reg_rdata(reg_rdata), .total_wr(total_wr), .lines_m1(lines_m1),
        .dots_m1(dots_m1), .interlace(interlace), .vs_lines(vs_lines),
        .hsw_code(hsw_code), .front_dots(front_dots), .back_dots(back_dots)
    );

    raster_counter u_cnt (
        .clk(clk), .rst_n(rst_n), .dot_en(dot_en), .clear(total_wr),
        .lines_m1(lines_m1), .dots_m1(dots_m1), .interlace(interlace),
        .line_cnt(line_cnt), .dot_cnt(dot_cnt), .field_odd(field_odd),
        .frame_cnt(frame_cnt)
    );

    raster_status u_stat (
        .line_cnt(line_cnt), .dot_cnt(dot_cnt), .field_odd(field_odd),
        .dots_m1(dots_m1), .vs_lines(vs_lines), .hsw_code(hsw_code),
        .front_dots(front_dots), .back_dots(back_dots), .status(status)
    );
endmodule

// File: rtl/raster_timing_chk.sv
// Property checker for the raster timing generator, bound to the top.
// Relates the counters, register port strobes and read data over time.
module raster_timing_chk
    import raster_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               dot_en,
    input logic               reg_wr,
    input logic               reg_rd,
    input logic [AW-1:0]      reg_addr,
    input logic [DW-1:0]      reg_rdata,
    input logic [LINE_W-1:0]  line_cnt,
    input logic [DOT_W-1:0]   dot_cnt,
    input logic               field_odd,
    input logic [FRAME_W-1:0] frame_cnt
);
    // R2
    total_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_TOTAL) |=> (dot_cnt == '0 && line_cnt == '0));

    // R3
    dot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!dot_en && !reg_wr) |=> $stable(dot_cnt));

    // R4
    field_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (field_odd != $past(field_odd)) |-> (line_cnt == '0));

    // R6
    frame_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (frame_cnt == $past(frame_cnt) || frame_cnt == $past(frame_cnt) + 1'b1));

    // R6
    frame_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_cnt != $past(frame_cnt)) |-> (line_cnt == RETRACE_END));

    // R7
    status_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == A_STATUS) |=> (reg_rdata[LINE_W-1:0] == $past(line_cnt)));
endmodule

bind raster_timing_gen raster_timing_chk u_chk (
    .clk(clk), .rst_n(rst_n), .dot_en(dot_en), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_rdata(reg_rdata),
    .line_cnt(line_cnt), .dot_cnt(dot_cnt), .field_odd(field_odd),
    .frame_cnt(frame_cnt)
);

// File: tb/raster_timing_gen_bench.sv
`timescale 1ns/1ps
module raster_timing_gen_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic dot_en = 1'b0, reg_wr = 1'b0, reg_rd = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [9:0]  line_cnt, dot_cnt;
    logic        field_odd;
    logic [15:0] frame_cnt;

    int total = 0;
    int bad = 0;

    // Reference model state
    logic [31:0] m_total, m_cfg, m_wid, m_porch;
    int m_dot, m_line, m_frame;
    logic m_field;

    always #10 clk = ~clk;

    raster_timing_gen u_raster_timing_gen (
        .clk(clk), .rst_n(rst_n), .dot_en(dot_en), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .line_cnt(line_cnt), .dot_cnt(dot_cnt),
        .field_odd(field_odd), .frame_cnt(frame_cnt)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] f_status();
        int dots, hs, lim, vs;
        logic hoff, voff, act;
        dots = int'(m_total[9:0]) + 1;
        hs   = (int'(m_wid[6:0]) + 1) * 2;
        vs   = int'(m_wid[11:8]);
        lim  = dots - int'(m_porch[25:16]);
        if (lim < 0) lim = 0;
        hoff = 0; voff = 0; act = 0;
        if ((m_line % 2) == int'(m_field)) begin
            hoff = (m_dot > hs);
            voff = (m_line >= vs);
            act  = (m_line >= vs) && (m_dot > int'(m_porch[9:0]));
        end else if (m_line >= vs) begin
            hoff = 1;
            voff = (m_dot < lim);
            act  = (m_dot < lim);
        end
        return {18'd0, voff, hoff, act, m_field, 10'(m_line)};
    endfunction

    function automatic logic [31:0] f_read(input logic [2:0] a);
        case (a)
            3'd0: return m_total;
            3'd1: return m_cfg;
            3'd2: return m_wid;
            3'd3: return m_porch;
            3'd4: return f_status();
            default: return 32'd0;
        endcase
    endfunction

    function automatic string f_rtag(input logic [2:0] a);
        if (a == 3'd4) return ((m_line % 2) == int'(m_field)) ? "R7/R8" : "R7/R9";
        if (a > 3'd4) return "R10";
        return "R5";
    endfunction

    task automatic model_reset();
        m_total = 32'h0270035F; m_cfg = 0; m_wid = 0; m_porch = 0;
        m_dot = 0; m_line = 0; m_frame = 0; m_field = 0;
    endtask

    task automatic model_step(input logic en, input logic wr, input logic [2:0] a, input logic [31:0] wd);
        if (en && !(wr && a == 3'd0)) begin
            if (m_dot == int'(m_total[9:0])) begin
                m_dot = 0;
                if (m_line == int'(m_total[25:16])) begin
                    m_line = 0;
                    if (m_cfg[4]) m_field = ~m_field;
                end else begin
                    m_line++;
                    if (m_line == 42) m_frame = (m_frame + 1) % 65536;
                end
            end else m_dot++;
        end
        if (wr) begin
            case (a)
                3'd0: begin m_total = wd & 32'h03FF03FF; m_dot = 0; m_line = 0; end
                3'd1: m_cfg = wd & 32'h3FF;
                3'd2: m_wid = wd & 32'hF7F;
                3'd3: m_porch = wd & 32'h03FF03FF;
                default: ;
            endcase
        end
    endtask

    // One clock cycle: drive at negedge, update model at posedge, check at negedge.
    task automatic step(input logic en, input logic wr, input logic rd,
                        input logic [2:0] a, input logic [31:0] wd);
        logic [31:0] exp_rd;
        string rtag;
        dot_en = en; reg_wr = wr; reg_rd = rd; reg_addr = a; reg_wdata = wd;
        exp_rd = f_read(a);
        rtag = f_rtag(a);
        @(posedge clk);
        model_step(en, wr, a, wd);
        @(negedge clk);
        dot_en = 0; reg_wr = 0; reg_rd = 0;
        chk("R3 dot", 32'(dot_cnt), 32'(m_dot));
        chk("R4 line/field", {21'd0, field_odd, line_cnt}, {21'd0, m_field, 10'(m_line)});
        chk("R6 frame", 32'(frame_cnt), 32'(m_frame));
        if (rd) chk(rtag, reg_rdata, exp_rd);
    endtask

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog (all requirements) actual=timeout expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state and reset totals value
        chk("R1 dot", 32'(dot_cnt), 0);
        chk("R1 line", 32'(line_cnt), 0);
        chk("R1 field/frame", {15'd0, field_odd, frame_cnt}, 0);
        step(0, 0, 1, 3'd0, 0);
        chk("R1 totals", reg_rdata, 32'h0270035F);

        // R5 masks on readback
        step(0, 1, 0, 3'd1, 32'hFFFFFFFF); step(0, 0, 1, 3'd1, 0);
        step(0, 1, 0, 3'd2, 32'hFFFFFFFF); step(0, 0, 1, 3'd2, 0);
        step(0, 1, 0, 3'd3, 32'hFFFFFFFF); step(0, 0, 1, 3'd3, 0);
        // R2 mask and counter clear after some dots
        for (int i = 0; i < 30; i++) step(1, 0, 0, 3'd0, 0);
        step(0, 1, 0, 3'd0, 32'hFFFFFFFF);
        chk("R2 clear", {12'd0, line_cnt, dot_cnt}, 0);
        step(0, 0, 1, 3'd0, 0);
        chk("R2 mask", reg_rdata, 32'h03FF03FF);

        // Random configurations
        for (int c = 0; c < 7; c++) begin
            logic [31:0] lines, dots;
            lines = 32'd43 + ($urandom % 17);
            dots  = 32'd15 + ($urandom % 25);
            step(0, 1, 0, 3'd1, (c == 3) ? 32'h0 : 32'h10 | ($urandom & 32'h3EF));
            step(0, 1, 0, 3'd2, $urandom);
            step(0, 1, 0, 3'd3, ($urandom % 31) | (($urandom % 31) << 16));
            step(1, 1, 0, 3'd0, (lines << 16) | dots | 32'hFC00FC00);
            chk("R2 clear", {12'd0, line_cnt, dot_cnt}, 0);
            for (int i = 0; i < 3800; i++) begin
                int r;
                logic [2:0] a;
                r = $urandom % 100;
                a = (r < 80) ? 3'd4 : 3'($urandom % 8);
                if (r == 99)      step(($urandom % 4) != 0, 1, 0, 3'd4 + 3'($urandom % 4), $urandom);
                else if (r < 40)  step(($urandom % 4) != 0, 0, 1, a, 0);
                else              step(($urandom % 4) != 0, 0, 0, 3'd0, 0);
            end
        end

        // R10 directed: write status and unmapped words, then read
        step(0, 1, 0, 3'd4, 32'hFFFFFFFF);
        step(0, 0, 1, 3'd4, 0);
        chk("R10 status kept", reg_rdata, f_status());
        step(0, 1, 0, 3'd7, 32'hFFFFFFFF);
        step(0, 0, 1, 3'd7, 0);
        chk("R10 unmapped", reg_rdata, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule